// File: doc/BRIEF.md
# Speculation Fence Quiesce Controller

This controller sits next to the issue stage of an out-of-order core. It returns the speculative machinery to a known idle state before untrusted code is allowed to run. One source of fence requests is an explicit hint from decode. The commit logic adds the other three: trap, interrupt and system call. Any of the four makes the controller block issue and send a one-cycle flush request to the speculative structures. It then waits until every tracked resource reports empty. Examples of tracked resources are reservation stations, operand forwarding paths and shared functional units such as a divider. After one acknowledge cycle, issue resumes.

The core also supplies a predicted distance, in instructions, to the next system call. When that distance is short, the controller moves to a throttled mode. In this mode only non-speculative issue is allowed, so no speculative work is started and then discarded a few instructions later.

Top module: `spec_quiesce_ctrl`

## Requirements
- R1: After reset, `issue_en_o` and `spec_issue_en_o` are 1, `flush_req_o` and `fence_done_o` are 0, and `state_o` is 0. The state codes are run = 0, throttle = 1, drain = 2 and acknowledge = 3.
- R2: Any of `fence_hint_i`, `trap_i`, `irq_i` or `syscall_i` that is high at a clock edge in run or throttle moves the controller to drain. `issue_en_o` then goes low in the next cycle and stays low until the acknowledge cycle has ended.
- R3: `flush_req_o` is high for exactly the first cycle of drain and at no other time.
- R4: Drain lasts at least one cycle. It persists as long as any bit of `busy_i` is high at a clock edge. The controller moves to acknowledge at the first edge in drain where all of `busy_i` is low.
- R5: Acknowledge lasts exactly one cycle with `fence_done_o` high. The controller then returns to run with both issue enables high.
- R6: Fence events that arrive during drain or acknowledge are absorbed. They cause no second flush pulse and do not lengthen the sequence.
- R7: In run, an edge at which `sc_dist_valid_i` is 1 and `sc_dist_i` is at most THRESH (default 10) moves the controller to throttle. In throttle `issue_en_o` is 1 and `spec_issue_en_o` is 0.
- R8: Throttle returns to run at the first edge where `sc_dist_valid_i` is 0 or `sc_dist_i` exceeds THRESH.
- R9: `spec_issue_en_o` is never high while `issue_en_o` is low.
- R10: When a fence event and the throttle condition occur at the same edge, the fence takes priority and the controller enters drain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fence_hint_i | input | 1 | Fence hint from decode |
| trap_i | input | 1 | Trap taken at commit |
| irq_i | input | 1 | Interrupt taken at commit |
| syscall_i | input | 1 | System call at commit |
| sc_dist_valid_i | input | 1 | Predicted system-call distance is valid |
| sc_dist_i | input | DIST_W | Predicted instructions until the system call |
| busy_i | input | NUM_BUSY | Per-resource occupancy flags |
| issue_en_o | output | 1 | Any issue allowed |
| spec_issue_en_o | output | 1 | Speculative issue allowed |
| flush_req_o | output | 1 | One-cycle flush request |
| fence_done_o | output | 1 | Quiescent acknowledge |
| state_o | output | 2 | Current state code |

## Verification
A wrong internal state shows up at the ports within one cycle. Every output is decoded from the registered state, so a missed transition is visible at once. If a fence is lost, `issue_en_o` stays high in the cycle after the event. If the controller leaves drain too early, `fence_done_o` rises while a busy flag is still set. If a drain restarts, `flush_req_o` pulses a second time. If the throttle state is wrong, the two issue enables disagree with the predicted distance one cycle after it is sampled.

// File: rtl/sqc_pkg.sv
package sqc_pkg;
  typedef enum logic [1:0] {
    ST_RUN      = 2'd0,
    ST_THROTTLE = 2'd1,
    ST_DRAIN    = 2'd2,
    ST_IDLE_ACK = 2'd3
  } sqc_state_e;
endpackage

// File: rtl/sqc_event_merge.sv
module sqc_event_merge #(
  parameter int N_SRC = 4
) (
  input  logic [N_SRC-1:0] src_i,
  output logic             any_o
);
  logic [N_SRC:0] acc;
  assign acc[0] = 1'b0;
  for (genvar g = 0; g < N_SRC; g++) begin : g_or
    assign acc[g+1] = acc[g] | src_i[g];
  end
  assign any_o = acc[N_SRC];
endmodule

// File: rtl/sqc_throttle_det.sv
module sqc_throttle_det #(
  parameter int DIST_W = 6,
  parameter int THRESH = 10
) (
  input  logic              valid_i,
  input  logic [DIST_W-1:0] dist_i,
  output logic              near_o
);
  localparam logic [DIST_W-1:0] THR_V = DIST_W'(THRESH);
  assign near_o = valid_i && (dist_i <= THR_V);
endmodule

// File: rtl/sqc_busy_agg.sv
module sqc_busy_agg #(
  parameter int NUM_BUSY = 4
) (
  input  logic [NUM_BUSY-1:0] busy_i,
  output logic                idle_o
);
  logic [NUM_BUSY:0] acc;
  assign acc[0] = 1'b0;
  for (genvar g = 0; g < NUM_BUSY; g++) begin : g_busy
    assign acc[g+1] = acc[g] | busy_i[g];
  end
  assign idle_o = ~acc[NUM_BUSY];
endmodule

// File: rtl/sqc_fsm.sv
module sqc_fsm
  import sqc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       fence_i,
  input  logic       near_i,
  input  logic       idle_i,
  output sqc_state_e state_o,
  output logic       flush_o
);
  sqc_state_e state_q, state_d;
  logic       flush_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN: begin
        if (fence_i)     state_d = ST_DRAIN;
        else if (near_i) state_d = ST_THROTTLE;
      end
      ST_THROTTLE: begin
        if (fence_i)      state_d = ST_DRAIN;
        else if (!near_i) state_d = ST_RUN;
      end
      ST_DRAIN:    if (idle_i) state_d = ST_IDLE_ACK;
      ST_IDLE_ACK: state_d = ST_RUN;
      default:     state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RUN;
      flush_q <= 1'b0;
    end else begin
      state_q <= state_d;
      // pulse only on the edge that enters drain
      flush_q <= (state_d == ST_DRAIN) && (state_q != ST_DRAIN);
    end
  end

  assign state_o = state_q;
  assign flush_o = flush_q;
endmodule

// File: rtl/spec_quiesce_ctrl.sv
module spec_quiesce_ctrl
  import sqc_pkg::*;
#(
  parameter int DIST_W   = 6,
  parameter int THRESH   = 10,
  parameter int NUM_BUSY = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                fence_hint_i,
  input  logic                trap_i,
  input  logic                irq_i,
  input  logic                syscall_i,
  input  logic                sc_dist_valid_i,
  input  logic [DIST_W-1:0]   sc_dist_i,
  input  logic [NUM_BUSY-1:0] busy_i,
  output logic                issue_en_o,
  output logic                spec_issue_en_o,
  output logic                flush_req_o,
  output logic                fence_done_o,
  output logic [1:0]          state_o
);
  localparam int N_SRC = 4;

  logic       fence_any, near, idle;
  sqc_state_e state;

  sqc_event_merge #(.N_SRC(N_SRC)) u_merge (
    .src_i ({syscall_i, irq_i, trap_i, fence_hint_i}),
    .any_o (fence_any)
  );

  sqc_throttle_det #(.DIST_W(DIST_W), .THRESH(THRESH)) u_thr (
    .valid_i (sc_dist_valid_i),
    .dist_i  (sc_dist_i),
    .near_o  (near)
  );

  sqc_busy_agg #(.NUM_BUSY(NUM_BUSY)) u_busy (
    .busy_i (busy_i),
    .idle_o (idle)
  );

  sqc_fsm u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fence_i (fence_any),
    .near_i  (near),
    .idle_i  (idle),
    .state_o (state),
    .flush_o (flush_req_o)
  );

  assign issue_en_o      = (state == ST_RUN) || (state == ST_THROTTLE);
  assign spec_issue_en_o = (state == ST_RUN);
  assign fence_done_o    = (state == ST_IDLE_ACK);
  assign state_o         = state;
endmodule

// File: rtl/sqc_checker.sv
module sqc_checker #(
  parameter int DIST_W   = 6,
  parameter int THRESH   = 10,
  parameter int NUM_BUSY = 4
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                fence_hint_i,
  input logic                trap_i,
  input logic                irq_i,
  input logic                syscall_i,
  input logic                sc_dist_valid_i,
  input logic [DIST_W-1:0]   sc_dist_i,
  input logic [NUM_BUSY-1:0] busy_i,
  input logic                issue_en_o,
  input logic                spec_issue_en_o,
  input logic                flush_req_o,
  input logic                fence_done_o
);
  logic evt, near_c;
  assign evt    = fence_hint_i | trap_i | irq_i | syscall_i;
  assign near_c = sc_dist_valid_i && (int'(sc_dist_i) <= THRESH);

  // R2
  fence_blocks_issue_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt && issue_en_o) |=> (!issue_en_o && flush_req_o));

  // R3
  flush_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_req_o |=> !flush_req_o);

  // R4
  done_after_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!issue_en_o && !fence_done_o && (busy_i != '0)) |=> !fence_done_o);

  // R5
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fence_done_o |=> (!fence_done_o && issue_en_o && spec_issue_en_o));

  // R6
  absorb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!issue_en_o) |=> !flush_req_o);

  // R7
  throttle_enter_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_en_o && !evt && near_c) |=> (issue_en_o && !spec_issue_en_o));

  // R8
  throttle_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_en_o && !evt && !near_c) |=> spec_issue_en_o);

  // R9
  spec_implies_issue_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spec_issue_en_o |-> issue_en_o);
endmodule

bind spec_quiesce_ctrl sqc_checker #(
  .DIST_W(DIST_W), .THRESH(THRESH), .NUM_BUSY(NUM_BUSY)
) u_sqc_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .fence_hint_i(fence_hint_i), .trap_i(trap_i), .irq_i(irq_i), .syscall_i(syscall_i),
  .sc_dist_valid_i(sc_dist_valid_i), .sc_dist_i(sc_dist_i), .busy_i(busy_i),
  .issue_en_o(issue_en_o), .spec_issue_en_o(spec_issue_en_o),
  .flush_req_o(flush_req_o), .fence_done_o(fence_done_o)
);

// File: tb/spec_quiesce_ctrl_test.sv
module spec_quiesce_ctrl_test;
  localparam int DIST_W   = 6;
  localparam int NUM_BUSY = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic fence_hint_i = 1'b0, trap_i = 1'b0, irq_i = 1'b0, syscall_i = 1'b0;
  logic sc_dist_valid_i = 1'b0;
  logic [DIST_W-1:0]   sc_dist_i = '0;
  logic [NUM_BUSY-1:0] busy_i = '0;
  logic issue_en_o, spec_issue_en_o, flush_req_o, fence_done_o;
  logic [1:0] state_o;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  spec_quiesce_ctrl #(.DIST_W(DIST_W), .THRESH(10), .NUM_BUSY(NUM_BUSY)) uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .fence_hint_i(fence_hint_i), .trap_i(trap_i), .irq_i(irq_i), .syscall_i(syscall_i),
    .sc_dist_valid_i(sc_dist_valid_i), .sc_dist_i(sc_dist_i), .busy_i(busy_i),
    .issue_en_o(issue_en_o), .spec_issue_en_o(spec_issue_en_o),
    .flush_req_o(flush_req_o), .fence_done_o(fence_done_o), .state_o(state_o)
  );

  // packed {issue, spec, flush, done, state}
  task automatic expect_out(string req, logic iss, logic spc, logic fl, logic dn, logic [1:0] st);
    logic [5:0] act, exp;
    act = {issue_en_o, spec_issue_en_o, flush_req_o, fence_done_o, state_o};
    exp = {iss, spc, fl, dn, st};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b (issue,spec,flush,done,state)", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic clear_events();
    fence_hint_i = 1'b0; trap_i = 1'b0; irq_i = 1'b0; syscall_i = 1'b0;
  endtask

  task automatic t_reset();
    expect_out("R1 reset", 1, 1, 0, 0, 2'd0);
  endtask

  task automatic t_hint_fast();
    fence_hint_i = 1'b1;
    step(); clear_events();
    expect_out("R2 R3 hint enters drain", 0, 0, 1, 0, 2'd2);
    step();
    expect_out("R4 R5 ack after idle", 0, 0, 0, 1, 2'd3);
    step();
    expect_out("R5 back to run", 1, 1, 0, 0, 2'd0);
  endtask

  task automatic t_trap_busy_absorb();
    busy_i = 4'b0100;
    trap_i = 1'b1;
    step(); clear_events();
    expect_out("R2 trap enters drain", 0, 0, 1, 0, 2'd2);
    fence_hint_i = 1'b1; irq_i = 1'b1;
    step(); clear_events();
    expect_out("R6 event in drain absorbed", 0, 0, 0, 0, 2'd2);
    busy_i = 4'b1001;
    step();
    expect_out("R4 drain holds while busy", 0, 0, 0, 0, 2'd2);
    busy_i = 4'b0000;
    step();
    expect_out("R4 ack once idle", 0, 0, 0, 1, 2'd3);
    syscall_i = 1'b1;
    step(); clear_events();
    expect_out("R6 event in ack absorbed", 1, 1, 0, 0, 2'd0);
    step();
    expect_out("R6 no late flush", 1, 1, 0, 0, 2'd0);
  endtask

  task automatic t_irq_syscall();
    irq_i = 1'b1;
    step(); clear_events();
    expect_out("R2 irq enters drain", 0, 0, 1, 0, 2'd2);
    step(); step();
    expect_out("R5 run after irq fence", 1, 1, 0, 0, 2'd0);
    syscall_i = 1'b1;
    step(); clear_events();
    expect_out("R2 syscall enters drain", 0, 0, 1, 0, 2'd2);
    step(); step();
  endtask

  task automatic t_throttle();
    sc_dist_valid_i = 1'b1; sc_dist_i = 6'd11;
    step();
    expect_out("R7 distance 11 stays run", 1, 1, 0, 0, 2'd0);
    sc_dist_i = 6'd10;
    step();
    expect_out("R7 distance 10 throttles", 1, 0, 0, 0, 2'd1);
    sc_dist_i = 6'd0;
    step();
    expect_out("R7 distance 0 stays throttled", 1, 0, 0, 0, 2'd1);
    sc_dist_i = 6'd11;
    step();
    expect_out("R8 distance 11 leaves throttle", 1, 1, 0, 0, 2'd0);
    sc_dist_valid_i = 1'b0; sc_dist_i = 6'd3;
    step();
    expect_out("R7 invalid distance ignored", 1, 1, 0, 0, 2'd0);
    sc_dist_valid_i = 1'b1;
    step();
    expect_out("R7 distance 3 throttles", 1, 0, 0, 0, 2'd1);
    sc_dist_valid_i = 1'b0;
    step();
    expect_out("R8 valid low leaves throttle", 1, 1, 0, 0, 2'd0);
  endtask

  task automatic t_fence_in_throttle();
    sc_dist_valid_i = 1'b1; sc_dist_i = 6'd5;
    step();
    expect_out("R7 throttle before fence", 1, 0, 0, 0, 2'd1);
    trap_i = 1'b1;
    step(); clear_events();
    expect_out("R2 fence from throttle", 0, 0, 1, 0, 2'd2);
    step();
    expect_out("R9 ack in throttle path", 0, 0, 0, 1, 2'd3);
    step();
    expect_out("R5 ack returns to run", 1, 1, 0, 0, 2'd0);
    step();
    expect_out("R7 rethrottle after run", 1, 0, 0, 0, 2'd1);
    sc_dist_valid_i = 1'b0;
    step();
  endtask

  task automatic t_priority();
    sc_dist_valid_i = 1'b1; sc_dist_i = 6'd2;
    fence_hint_i = 1'b1;
    step(); clear_events(); sc_dist_valid_i = 1'b0;
    expect_out("R10 fence beats throttle", 0, 0, 1, 0, 2'd2);
    step(); step();
    expect_out("R5 run after priority case", 1, 1, 0, 0, 2'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_ni = 1'b1;
    #1;
    t_reset();
    step();
    t_hint_fast();
    t_trap_busy_absorb();
    t_irq_syscall();
    t_throttle();
    t_fence_in_throttle();
    t_priority();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule